// File: doc/BRIEF.md
# HDLC Latched Event and Interrupt Register

This block collects the events of a transmit and a receive HDLC path into seven sticky status bits. A host reads the bits through a small register port and clears each one by writing a 1 to its position. Single-cycle pulses set the packet start, packet end and abort bits. The two FIFO watermark bits are set on a low-to-high transition of a live level. The underrun bit has its own arming rule: it can only be set again once the transmit FIFO has been written to since the last underrun.

A per-bit enable register and a single group enable decide which latched bits raise the interrupt output. A latched bit drives the interrupt only while both its own enable and the group enable are 1. The interrupt is computed from registered state, so it drops in the cycle after the bit or either enable is cleared.

Top module: `hdlc_evt_latch`

## Requirements
- R1: After reset, the status register, the enable register and the group enable all read 0, and `irq` is 0.
- R2: Status bit positions are fixed: bit 0 transmit packet end, bit 1 transmit underrun, bit 2 transmit low watermark, bit 3 receive high watermark, bit 4 receive abort, bit 5 receive packet start, bit 6 receive packet end. A pulse on `rxStartPulse`, `rxAbortPulse` or `rxEndPulse` sets its bit on the next clock edge. Bit 7 always reads 0.
- R3: A write to address 0 clears every status bit whose data bit is 1. Bits written with 0 keep their value.
- R4: Bit 0 is set by `txEndPulse` (a FIFO byte tagged as end of packet was consumed). It is also set by any `txUnderrunPulse`.
- R5: An underrun sets bit 1 only if `txFifoWrite` has been seen since reset or since the previous underrun pulse. An underrun without an intervening write leaves bit 1 clear.
- R6: Bits 2 and 3 are set when `txLowWmLevel` or `rxHighWmLevel` changes from low to high. A level that stays high does not set the bit again after a clear. A level sampled high in the first cycle after reset counts as a rising edge.
- R7: `irq` is 1 exactly when some status bit is 1, its enable bit at address 1 is 1, and the group enable (address 2, bit 0) is 1.
- R8: `irq` falls in the cycle after the last enabled status bit is cleared, or after its enable or the group enable is written to 0.
- R9: When a set event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: Address map: 0 is status (write 1 to clear), 1 is the enable register (bits 6:0, bit 7 reads 0), 2 is the group enable (bit 0), and 3 reads 0. Reads are combinational and have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| txEndPulse | input | 1 | Transmit consumed a byte tagged end of packet |
| txUnderrunPulse | input | 1 | Transmit FIFO underran |
| txFifoWrite | input | 1 | Transmit FIFO was written |
| txLowWmLevel | input | 1 | Live transmit low watermark level |
| rxHighWmLevel | input | 1 | Live receive high watermark level |
| rxAbortPulse | input | 1 | Abort detected inside a packet |
| rxStartPulse | input | 1 | Packet start detected |
| rxEndPulse | input | 1 | Closing flag detected |
| hostAddr | input | 2 | Register address |
| hostWr | input | 1 | Write strobe |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Read data for hostAddr |
| irq | output | 1 | Interrupt request |

## Verification
A stuck or mis-wired status bit shows up in the first status read after its event, one clock after the pulse. A wrong underrun arming flag shows as a bit 1 that reappears after an underrun with no FIFO write before it, or one that never appears. A watermark edge detector that tracks the level, not its transitions, re-sets the bit right after a clear while the level is still high. Enable or group gating errors show on `irq` one cycle after the enable write that should change it.

// File: rtl/hdlc_evt_pkg.sv
package hdlc_evt_pkg;
  localparam int NUM_EVT = 7;

  localparam int BIT_TX_END  = 0;
  localparam int BIT_TX_URUN = 1;
  localparam int BIT_TX_LWM  = 2;
  localparam int BIT_RX_HWM  = 3;
  localparam int BIT_RX_ABT  = 4;
  localparam int BIT_RX_SOP  = 5;
  localparam int BIT_RX_EOP  = 6;

  localparam logic [1:0] ADR_STAT = 2'd0;
  localparam logic [1:0] ADR_EN   = 2'd1;
  localparam logic [1:0] ADR_GRP  = 2'd2;

  typedef struct packed {
    logic [NUM_EVT-1:0] setVec;
    logic [NUM_EVT-1:0] clrMask;
    logic               enWr;
    logic               grpWr;
  } evtStrobe_t;
endpackage

// File: rtl/hdlc_evt_ctrl.sv
module hdlc_evt_ctrl
  import hdlc_evt_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEndPulse,
  input  logic              txUnderrunPulse,
  input  logic              txFifoWrite,
  input  logic              txLowWmLevel,
  input  logic              rxHighWmLevel,
  input  logic              rxAbortPulse,
  input  logic              rxStartPulse,
  input  logic              rxEndPulse,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWdata,
  output evtStrobe_t        strb
);
  logic urunArmed;
  logic lowWmPrev;
  logic highWmPrev;
  logic lowWmRise;
  logic highWmRise;
  logic statWr;
  wire  unusedWdata = ^hostWdata[DATA_W-1:NUM_EVT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      urunArmed  <= 1'b1;
      lowWmPrev  <= 1'b0;
      highWmPrev <= 1'b0;
    end else begin
      lowWmPrev  <= txLowWmLevel;
      highWmPrev <= rxHighWmLevel;
      if (txUnderrunPulse)  urunArmed <= 1'b0;
      else if (txFifoWrite) urunArmed <= 1'b1;
    end
  end

  assign lowWmRise  = txLowWmLevel & ~lowWmPrev;
  assign highWmRise = rxHighWmLevel & ~highWmPrev;
  assign statWr     = hostWr && (hostAddr == ADDR_W'(ADR_STAT));

  always_comb begin
    strb = '0;
    strb.setVec[BIT_TX_END]  = txEndPulse | txUnderrunPulse;
    strb.setVec[BIT_TX_URUN] = txUnderrunPulse & urunArmed;
    strb.setVec[BIT_TX_LWM]  = lowWmRise;
    strb.setVec[BIT_RX_HWM]  = highWmRise;
    strb.setVec[BIT_RX_ABT]  = rxAbortPulse;
    strb.setVec[BIT_RX_SOP]  = rxStartPulse;
    strb.setVec[BIT_RX_EOP]  = rxEndPulse;
    strb.clrMask = statWr ? hostWdata[NUM_EVT-1:0] : '0;
    strb.enWr    = hostWr && (hostAddr == ADDR_W'(ADR_EN));
    strb.grpWr   = hostWr && (hostAddr == ADDR_W'(ADR_GRP));
  end

  // R6
  wm_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setVec[BIT_TX_LWM] |=> !strb.setVec[BIT_TX_LWM]);
  // R5
  urun_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setVec[BIT_TX_URUN] |=> !strb.setVec[BIT_TX_URUN]);
endmodule

// File: rtl/hdlc_evt_datapath.sv
module hdlc_evt_datapath
  import hdlc_evt_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  evtStrobe_t        strb,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic [DATA_W-1:0] hostRdata,
  output logic              irq
);
  logic [NUM_EVT-1:0] stat;
  logic [NUM_EVT-1:0] evtEn;
  logic               grpEn;
  wire  unusedWdata = ^hostWdata[DATA_W-1:NUM_EVT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stat  <= '0;
      evtEn <= '0;
      grpEn <= 1'b0;
    end else begin
      stat <= (stat & ~strb.clrMask) | strb.setVec;
      if (strb.enWr)  evtEn <= hostWdata[NUM_EVT-1:0];
      if (strb.grpWr) grpEn <= hostWdata[0];
    end
  end

  assign irq = grpEn & (|(stat & evtEn));

  always_comb begin
    hostRdata = '0;
    case (hostAddr)
      ADDR_W'(ADR_STAT): hostRdata[NUM_EVT-1:0] = stat;
      ADDR_W'(ADR_EN):   hostRdata[NUM_EVT-1:0] = evtEn;
      ADDR_W'(ADR_GRP):  hostRdata[0] = grpEn;
      default:           hostRdata = '0;
    endcase
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setVec != '0) |=> ((stat & $past(strb.setVec)) == $past(strb.setVec)));
  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.clrMask & ~strb.setVec) != '0) |=> ((stat & $past(strb.clrMask & ~strb.setVec)) == '0));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setVec == '0 && strb.clrMask == '0) |=> $stable(stat));
  // R8
  grp_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(grpEn) |-> !irq);
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (stat != '0));
endmodule

// File: rtl/hdlc_evt_latch.sv
module hdlc_evt_latch
  import hdlc_evt_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEndPulse,
  input  logic              txUnderrunPulse,
  input  logic              txFifoWrite,
  input  logic              txLowWmLevel,
  input  logic              rxHighWmLevel,
  input  logic              rxAbortPulse,
  input  logic              rxStartPulse,
  input  logic              rxEndPulse,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              irq
);
  evtStrobe_t strb;

  hdlc_evt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .txEndPulse(txEndPulse), .txUnderrunPulse(txUnderrunPulse),
    .txFifoWrite(txFifoWrite), .txLowWmLevel(txLowWmLevel),
    .rxHighWmLevel(rxHighWmLevel), .rxAbortPulse(rxAbortPulse),
    .rxStartPulse(rxStartPulse), .rxEndPulse(rxEndPulse),
    .hostAddr(hostAddr), .hostWr(hostWr), .hostWdata(hostWdata),
    .strb(strb)
  );

  hdlc_evt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostWdata(hostWdata), .hostAddr(hostAddr),
    .hostRdata(hostRdata), .irq(irq)
  );
endmodule

// File: tb/sim_hdlc_evt_latch.sv
`timescale 1ns/1ps
module sim_hdlc_evt_latch;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEndPulse = 0, txUnderrunPulse = 0, txFifoWrite = 0;
  logic txLowWmLevel = 0, rxHighWmLevel = 0;
  logic rxAbortPulse = 0, rxStartPulse = 0, rxEndPulse = 0;
  logic [1:0] hostAddr = 2'd0;
  logic hostWr = 0;
  logic [7:0] hostWdata = 8'd0;
  logic [7:0] hostRdata;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    bit         isIrq;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  hdlc_evt_latch u0 (
    .clk(clk), .rstN(rstN),
    .txEndPulse(txEndPulse), .txUnderrunPulse(txUnderrunPulse),
    .txFifoWrite(txFifoWrite), .txLowWmLevel(txLowWmLevel),
    .rxHighWmLevel(rxHighWmLevel), .rxAbortPulse(rxAbortPulse),
    .rxStartPulse(rxStartPulse), .rxEndPulse(rxEndPulse),
    .hostAddr(hostAddr), .hostWr(hostWr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .irq(irq)
  );

  // monitor: compares queued expectations one negedge after they are pushed
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sbq.pop_front();
        act = it.isIrq ? {7'd0, irq} : hostRdata;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic expRead(input logic [1:0] a, input logic [7:0] e, input string tag);
    hostAddr = a;
    sbq.push_back('{isIrq: 1'b0, exp: e, tag: tag});
    step();
  endtask

  task automatic expIrq(input logic e, input string tag);
    sbq.push_back('{isIrq: 1'b1, exp: {7'd0, e}, tag: tag});
    step();
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    hostAddr = a; hostWdata = d; hostWr = 1;
    step();
    hostWr = 0;
  endtask

  initial begin
    step(); step();
    rstN = 1;
    step();
    // R1 reset state
    expRead(2'd0, 8'h00, "R1 status");
    expRead(2'd1, 8'h00, "R1 enable");
    expRead(2'd2, 8'h00, "R1 group");
    expIrq(1'b0, "R1 irq");

    // R2 receive start pulse sets bit 5
    rxStartPulse = 1; step(); rxStartPulse = 0;
    expRead(2'd0, 8'h20, "R2 packet start bit5");
    // R3 writing zero keeps the bit
    hostWrite(2'd0, 8'h00);
    expRead(2'd0, 8'h20, "R3 write zero no effect");
    hostWrite(2'd0, 8'h20);
    expRead(2'd0, 8'h00, "R3 write one clears");

    // R4 tagged byte sets bit 0, underrun also sets bit 0; R5 first underrun armed
    txEndPulse = 1; step(); txEndPulse = 0;
    expRead(2'd0, 8'h01, "R4 packet end bit0");
    hostWrite(2'd0, 8'h01);
    txUnderrunPulse = 1; step(); txUnderrunPulse = 0;
    expRead(2'd0, 8'h03, "R4 R5 underrun after reset");
    hostWrite(2'd0, 8'h03);
    txUnderrunPulse = 1; step(); txUnderrunPulse = 0;
    expRead(2'd0, 8'h01, "R5 underrun without write not rearmed");
    hostWrite(2'd0, 8'h01);
    txFifoWrite = 1; step(); txFifoWrite = 0;
    expRead(2'd0, 8'h00, "R5 fifo write alone sets nothing");
    txUnderrunPulse = 1; step(); txUnderrunPulse = 0;
    expRead(2'd0, 8'h03, "R5 underrun after write");
    hostWrite(2'd0, 8'h03);

    // R6 watermark edges
    txLowWmLevel = 1; step();
    expRead(2'd0, 8'h04, "R6 low watermark rise");
    hostWrite(2'd0, 8'h04);
    expRead(2'd0, 8'h00, "R6 level held high no reset");
    txLowWmLevel = 0; step(); txLowWmLevel = 1; step();
    expRead(2'd0, 8'h04, "R6 low watermark second rise");
    rxHighWmLevel = 1; step();
    expRead(2'd0, 8'h0C, "R6 high watermark rise");
    hostWrite(2'd0, 8'h0C);
    expRead(2'd0, 8'h00, "R6 both cleared while high");
    txLowWmLevel = 0; rxHighWmLevel = 0; step();

    // R2 abort and end
    rxAbortPulse = 1; step(); rxAbortPulse = 0;
    rxEndPulse = 1; step(); rxEndPulse = 0;
    expRead(2'd0, 8'h50, "R2 abort and end bits");

    // R10 enable register bit 7 and address 3
    hostWrite(2'd1, 8'hFF);
    expRead(2'd1, 8'h7F, "R10 enable bit7 reads 0");
    expRead(2'd3, 8'h00, "R10 address 3 reads 0");
    expRead(2'd0, 8'h50, "R10 read no side effect");

    // R7 / R8 interrupt gating
    hostWrite(2'd1, 8'h10);
    expIrq(1'b0, "R7 group off");
    hostWrite(2'd2, 8'h01);
    expRead(2'd2, 8'h01, "R10 group readback");
    expIrq(1'b1, "R7 both enables on");
    hostWrite(2'd1, 8'h20);
    expIrq(1'b0, "R8 enable moved to clear bit");
    hostWrite(2'd1, 8'h40);
    expIrq(1'b1, "R7 end bit enabled");
    hostWrite(2'd0, 8'h40);
    expIrq(1'b0, "R8 bit cleared drops irq");
    hostWrite(2'd1, 8'h10);
    expIrq(1'b1, "R7 abort enabled");
    hostWrite(2'd2, 8'h00);
    expIrq(1'b0, "R8 group cleared drops irq");

    // R9 set wins over clear
    hostWrite(2'd0, 8'h7F);
    expRead(2'd0, 8'h00, "R9 precondition cleared");
    hostAddr = 2'd0; hostWdata = 8'h10; hostWr = 1; rxAbortPulse = 1;
    step();
    hostWr = 0; rxAbortPulse = 0;
    expRead(2'd0, 8'h10, "R9 set wins");

    step(); step();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule